// File: doc/BRIEF.md
# Hold-and-Modify Pixel Colour Decoder

This block turns bitplane pixel codes into 12-bit RGB colours, four bits per component. Each code is either a palette index or an instruction to repeat the previous output colour with one component replaced. Its output therefore depends on the colour it produced last. The block keeps this colour in a held-colour register. The register changes only when a pixel is accepted or when border output resumes.

Each cycle carries two output slots, `out_a` followed by `out_b`. In high resolution the two slots take two separate codes, and the second code is decoded against the result of the first. In low resolution a single code is decoded and its colour fills both slots. A write port loads palette entries. The `border` input reloads the held colour from palette entry 0, so the first modify pixel after a border modifies the border colour.

Top module: `hmd_decoder`

## Requirements
- R1: After reset, `out_valid` is 0, both output slots are 0, the held colour is 0, and every palette entry reads as 0.
- R2: A code whose bits 5:4 are 00 outputs palette entry [bits 3:0] and makes that entry the held colour.
- R3: A code whose bits 5:4 are 01 outputs the held red (11:8) and green (7:4) with blue (3:0) replaced by code bits 3:0.
- R4: A code whose bits 5:4 are 10 outputs the held green and blue with red (11:8) replaced by code bits 3:0.
- R5: A code whose bits 5:4 are 11 outputs the held red and blue with green (7:4) replaced by code bits 3:0.
- R6: On a cycle with `pix_valid` low and `border` low, the held colour does not change, `out_valid` falls, and both output slots keep their values.
- R7: On a cycle with `border` high, the held colour is loaded from palette entry 0 and no pixel is produced, even if `pix_valid` is high.
- R8: With `lores` high, only `code_a` is decoded, `out_b` equals `out_a`, and `code_b` has no effect.
- R9: With `lores` low, `code_b` is decoded against the colour produced for `code_a` in the same cycle, and the `out_b` result becomes the held colour.
- R10: The outputs are registered. A pixel accepted at one clock edge appears with `out_valid` high after that edge.
- R11: A palette write acts from the next cycle on. A pixel in the same cycle uses the old entry, and the write never alters the held colour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pal_we | input | 1 | Palette write enable |
| pal_addr | input | 4 | Palette entry to write |
| pal_wdata | input | 12 | Entry value, red 11:8, green 7:4, blue 3:0 |
| pix_valid | input | 1 | A pixel code pair is present this cycle |
| lores | input | 1 | Low resolution: one code fills both slots |
| border | input | 1 | Border output resumes; reload held colour from entry 0 |
| code_a | input | 6 | First pixel code; control 5:4, data 3:0 |
| code_b | input | 6 | Second pixel code, used in high resolution only |
| out_valid | output | 1 | Output slots carry a new pixel pair |
| out_a | output | 12 | First output colour |
| out_b | output | 12 | Second output colour |

## Verification
A held-colour register that goes wrong shows first in a modify code. The next valid pixel whose control field is non-zero carries two stale components, one cycle after it is accepted. The fault persists until a palette-lookup code or a border cycle reloads the register. For this reason the stimulus keeps long runs of modify codes between lookups, and it places border cycles directly before modify pixels. A wrong chaining of the two slots shows in `out_b` in the same cycle. It shows again in the following pixel pair, which builds on that colour.

// File: rtl/hmd_decoder.sv
module hmd_decoder #(
  parameter int COMP_W = 4,
  localparam int RGB_W = 3 * COMP_W,
  localparam int CODE_W = COMP_W + 2,
  localparam int ENTRIES = 1 << COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pal_we,
  input  logic [COMP_W-1:0] pal_addr,
  input  logic [RGB_W-1:0]  pal_wdata,
  input  logic              pix_valid,
  input  logic              lores,
  input  logic              border,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  output logic              out_valid,
  output logic [RGB_W-1:0]  out_a,
  output logic [RGB_W-1:0]  out_b
);

  logic [RGB_W-1:0] palette [ENTRIES];
  logic [RGB_W-1:0] held;
  logic [RGB_W-1:0] dec_a, dec_b;

  function automatic logic [RGB_W-1:0] modify(input logic [RGB_W-1:0] h,
                                              input logic [CODE_W-1:0] c,
                                              input logic [RGB_W-1:0] p);
    case (c[CODE_W-1 -: 2])
      2'b00:   return p;
      2'b01:   return {h[RGB_W-1:COMP_W], c[COMP_W-1:0]};
      2'b10:   return {c[COMP_W-1:0], h[2*COMP_W-1:0]};
      default: return {h[RGB_W-1:2*COMP_W], c[COMP_W-1:0], h[COMP_W-1:0]};
    endcase
  endfunction

  assign dec_a = modify(held, code_a, palette[code_a[COMP_W-1:0]]);
  assign dec_b = lores ? dec_a : modify(dec_a, code_b, palette[code_b[COMP_W-1:0]]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) palette[i] <= '0;
    end else if (pal_we) begin
      palette[pal_addr] <= pal_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held      <= '0;
      out_valid <= 1'b0;
      out_a     <= '0;
      out_b     <= '0;
    end else begin
      out_valid <= pix_valid && !border;
      if (border) begin
        held <= palette[0];
      end else if (pix_valid) begin
        held  <= dec_b;
        out_a <= dec_a;
        out_b <= dec_b;
      end
    end
  end

endmodule

// File: rtl/hmd_decoder_chk.sv
module hmd_decoder_chk #(
  parameter int COMP_W = 4,
  localparam int RGB_W = 3 * COMP_W,
  localparam int CODE_W = COMP_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_valid,
  input logic              lores,
  input logic              border,
  input logic [CODE_W-1:0] code_a,
  input logic              out_valid,
  input logic [RGB_W-1:0]  out_a,
  input logic [RGB_W-1:0]  out_b,
  input logic [RGB_W-1:0]  held,
  input logic [RGB_W-1:0]  pal0
);

  // R10
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(pix_valid) && !$past(border));

  // R8
  lores_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(lores) |-> out_a == out_b);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_a) && $stable(out_b));

  // R3
  blue_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(code_a[CODE_W-1 -: 2]) == 2'b01 |->
      out_a == {$past(held[RGB_W-1:COMP_W]), $past(code_a[COMP_W-1:0])});

  // R4
  red_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(code_a[CODE_W-1 -: 2]) == 2'b10 |->
      out_a == {$past(code_a[COMP_W-1:0]), $past(held[2*COMP_W-1:0])});

  // R5
  green_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(code_a[CODE_W-1 -: 2]) == 2'b11 |->
      out_a == {$past(held[RGB_W-1:2*COMP_W]), $past(code_a[COMP_W-1:0]),
                $past(held[COMP_W-1:0])});

  // R7
  border_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(border) |-> held == $past(pal0) && !out_valid);

endmodule

bind hmd_decoder hmd_decoder_chk #(.COMP_W(COMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .lores(lores),
  .border(border), .code_a(code_a), .out_valid(out_valid),
  .out_a(out_a), .out_b(out_b), .held(held), .pal0(palette[0])
);

// File: tb/hmd_decoder_tb.sv
`timescale 1ns/1ps
module hmd_decoder_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic pal_we = 0;
  logic [3:0] pal_addr = 0;
  logic [11:0] pal_wdata = 0;
  logic pix_valid = 0, lores = 0, border = 0;
  logic [5:0] code_a = 0, code_b = 0;
  logic out_valid;
  logic [11:0] out_a, out_b;

  int checks = 0, errors = 0;
  logic [11:0] m_pal [16];
  logic [11:0] m_held, e_a, e_b;
  logic e_v;

  always #10 clk = ~clk;

  hmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .pal_we(pal_we), .pal_addr(pal_addr),
    .pal_wdata(pal_wdata), .pix_valid(pix_valid), .lores(lores),
    .border(border), .code_a(code_a), .code_b(code_b),
    .out_valid(out_valid), .out_a(out_a), .out_b(out_b)
  );

  function automatic logic [11:0] ref_mod(input logic [11:0] h, input logic [5:0] c);
    case (c[5:4])
      2'b00:   return m_pal[c[3:0]];
      2'b01:   return {h[11:4], c[3:0]};
      2'b10:   return {c[3:0], h[7:0]};
      default: return {h[11:8], c[3:0], h[3:0]};
    endcase
  endfunction

  function automatic string ctl_tag(input logic [5:0] c);
    case (c[5:4])
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic b, input logic lo,
                       input logic [5:0] ca, input logic [5:0] cb,
                       input logic we, input logic [3:0] ad, input logic [11:0] wd,
                       input string note);
    logic [11:0] a, bb;
    pix_valid = v; border = b; lores = lo; code_a = ca; code_b = cb;
    pal_we = we; pal_addr = ad; pal_wdata = wd;
    if (b) begin
      m_held = m_pal[0];
      e_v = 0;
    end else if (v) begin
      a = ref_mod(m_held, ca);
      bb = lo ? a : ref_mod(a, cb);
      e_a = a; e_b = bb; m_held = bb; e_v = 1;
    end else begin
      e_v = 0;
    end
    if (we) m_pal[ad] = wd;
    @(negedge clk);
    check({(v && !b) ? "R10" : (b ? "R7" : "R6"), " valid ", note}, {11'd0, out_valid}, {11'd0, e_v});
    check({(v && !b) ? ctl_tag(ca) : (b ? "R7" : "R6"), " slot a ", note}, out_a, e_a);
    check({lo ? "R8" : "R9", " slot b ", note}, out_b, e_b);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < 16; i++) m_pal[i] = 0;
    m_held = 0; e_a = 0; e_b = 0; e_v = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 valid after reset", {11'd0, out_valid}, 12'd0);
    check("R1 slot a after reset", out_a, 12'd0);
    check("R1 slot b after reset", out_b, 12'd0);
    drive(1, 0, 1, 6'h07, 6'h00, 0, 0, 0, "R1 palette reads zero");

    // palette load, lookup
    drive(0, 0, 0, 0, 0, 1, 4'd5, 12'hABC, "write 5");
    drive(0, 0, 0, 0, 0, 1, 4'd0, 12'h123, "write 0");
    drive(1, 0, 0, 6'h05, 6'h1F, 0, 0, 0, "R9 lookup then blue");
    drive(1, 0, 0, 6'h26, 6'h39, 0, 0, 0, "red then green");
    // R6 idle keeps held
    drive(0, 0, 0, 6'h05, 6'h05, 0, 0, 0, "R6 idle");
    drive(0, 0, 1, 6'h05, 6'h05, 0, 0, 0, "R6 idle");
    drive(1, 0, 1, 6'h1E, 6'h00, 0, 0, 0, "R6 held kept across idle");
    // R11 write same entry as lookup in same cycle
    drive(1, 0, 1, 6'h05, 6'h00, 1, 4'd5, 12'h777, "R11 old entry used");
    drive(1, 0, 1, 6'h11, 6'h00, 0, 0, 0, "R11 held not rewritten");
    drive(1, 0, 1, 6'h05, 6'h00, 0, 0, 0, "R11 new entry next cycle");
    // R7 border then modify
    drive(1, 1, 0, 6'h05, 6'h05, 0, 0, 0, "R7 border beats valid");
    drive(1, 0, 1, 6'h2F, 6'h00, 0, 0, 0, "R7 modify border colour");
    drive(0, 1, 0, 0, 0, 1, 4'd0, 12'hF0F, "R7 border uses old entry 0");
    drive(1, 0, 0, 6'h3A, 6'h1B, 0, 0, 0, "R7 modify after border");
    // R8 code_b ignored in lores
    drive(1, 0, 1, 6'h25, 6'h00, 0, 0, 0, "R8 code_b zero");
    drive(1, 0, 1, 6'h25, 6'h3F, 0, 0, 0, "R8 code_b ones");

    for (int i = 0; i < 3000; i++) begin
      logic v, b, lo, we;
      v  = ($urandom % 10) < 7;
      b  = ($urandom % 20) == 0;
      lo = ($urandom % 3) == 0;
      we = ($urandom % 8) == 0;
      drive(v, b, lo, 6'($urandom), 6'($urandom), we, 4'($urandom), 12'($urandom), "random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule